// File: doc/BRIEF.md
# UART Transmit Holding Buffer

This block is the transmit half of a UART. A bus master writes one character at a time into a single holding register. A shift register beside it serializes each character onto the serial line. One flag couples the two registers. While the flag is high, the holding register is empty and takes the next bus write. An accepted write drops the flag. The shift register raises the flag again when it takes the character over.

Each character goes out as an 8N1 frame. Time is counted in baud ticks, which are single-cycle enable pulses supplied from outside the block. The shift register picks up a waiting character on the same clock edge that ends the previous frame, so a steady stream of writes produces frames with no idle time between them. While the transmitter enable is low, bus writes are dropped. A frame that is already in flight still finishes.

Top module: `uart_tx_buffer`

## Requirements
- R1: After reset, `tx_ready` is 1 and `txd` is 1.
- R2: A cycle with `wr_stb`=1, `tx_en`=1 and `tx_ready`=1 captures `wr_data` in the holding register, and `tx_ready` reads 0 from the next cycle.
- R3: A write made while `tx_ready`=0 leaves the holding register unchanged, so the character sent next is the one accepted earlier.
- R4: A write made while `tx_en`=0 leaves the holding register unchanged. When no character is pending, `tx_ready` stays 1 and no frame starts.
- R5: When the shift register is empty and a character is waiting, the shift register loads it at the next clock edge. At that edge `tx_ready` returns to 1 and `txd` falls to the start bit. A write accepted while the line is idle therefore holds `tx_ready` low for exactly one cycle.
- R6: The frame order is one start bit at 0, then 8 data bits with bit 0 first, then one stop bit at 1.
- R7: Each bit lasts exactly 16 cycles in which `baud_tick`=1. Cycles without a tick do not advance the frame. Ticks that arrive while the line is idle are not counted.
- R8: If a character is waiting when a stop bit ends, the next start bit begins on that same clock edge, with no idle time.
- R9: When no frame is in progress, `txd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmitter enable; gates bus writes |
| baud_tick | input | 1 | Single-cycle baud enable pulse |
| wr_stb | input | 1 | Bus write strobe for the holding register |
| wr_data | input | 8 | Character to transmit |
| txd | output | 1 | Serial output |
| tx_ready | output | 1 | High when the holding register can take a write |

## Verification
The main function is exercised in three ways:
- **Single writes on an idle line.** These separate the one-cycle ready dip from the longer wait behind a frame in flight.
- **Writes landing during a frame.** Bursts with a tick on every cycle place writes mid-frame. This shows whether the waiting character starts on the edge that ends the stop bit, or one cycle later.
- **Random mixed traffic.** Sparse random ticks, random write strobes and occasional disabled cycles mix accepted writes with writes refused for low ready or low enable. A refused write that leaked into the holding register shows up as a wrong data bit in a later frame.

// File: rtl/uart_txb_pkg.sv
package uart_txb_pkg;

  // Frame layout: start bit + data bits + stop bit
  function automatic int frame_bits(input int data_w);
    return data_w + 2;
  endfunction

  // Index of the final bit position within a frame
  function automatic int last_bit_index(input int data_w);
    return frame_bits(data_w) - 1;
  endfunction

  // Counter width needed to hold values 0 .. n-1
  function automatic int count_width(input int n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/tx_hold_reg.sv
module tx_hold_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              tx_en,
  input  logic              load_evt,
  output logic [DATA_W-1:0] hold_q,
  output logic              ready_q,
  output logic              wr_accept
);

  // A write lands only when the slot is free and the transmitter is on
  assign wr_accept = wr_stb && tx_en && ready_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      ready_q <= 1'b1;
    end else if (wr_accept) begin
      hold_q  <= wr_data;
      ready_q <= 1'b0;
    end else if (load_evt) begin
      ready_q <= 1'b1;
    end
  end

endmodule

// File: rtl/tx_bit_timer.sv
module tx_bit_timer #(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  input  logic baud_tick,
  output logic bit_end
);
  import uart_txb_pkg::*;

  localparam int CW = count_width(TICKS_PER_BIT);
  localparam logic [CW-1:0] LAST_TICK = CW'(TICKS_PER_BIT - 1);

  logic [CW-1:0] tick_cnt;

  assign bit_end = run && baud_tick && (tick_cnt == LAST_TICK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_cnt <= '0;
    end else if (restart) begin
      tick_cnt <= '0;
    end else if (run && baud_tick) begin
      tick_cnt <= (tick_cnt == LAST_TICK) ? '0 : tick_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/tx_shifter.sv
module tx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              bit_end,
  output logic              txd,
  output logic              busy,
  output logic              frame_done
);
  import uart_txb_pkg::*;

  localparam int FRAME_W = frame_bits(DATA_W);
  localparam int IW      = count_width(FRAME_W);
  localparam logic [IW-1:0] LAST_IDX = IW'(last_bit_index(DATA_W));

  logic [FRAME_W-1:0] shreg;
  logic [IW-1:0]      bit_idx;

  // Stop bit high, data LSB first, start bit low in the bit that leaves first
  function automatic logic [FRAME_W-1:0] build_frame(input logic [DATA_W-1:0] d);
    return {1'b1, d, 1'b0};
  endfunction

  assign frame_done = busy && bit_end && (bit_idx == LAST_IDX);
  assign txd        = shreg[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '1;
      bit_idx <= '0;
      busy    <= 1'b0;
    end else if (load) begin
      shreg   <= build_frame(load_data);
      bit_idx <= '0;
      busy    <= 1'b1;
    end else if (frame_done) begin
      shreg   <= '1;
      bit_idx <= '0;
      busy    <= 1'b0;
    end else if (busy && bit_end) begin
      shreg   <= {1'b1, shreg[FRAME_W-1:1]};
      bit_idx <= bit_idx + 1'b1;
    end
  end

endmodule

// File: rtl/uart_tx_buffer.sv
module uart_tx_buffer #(
  parameter int DATA_W        = 8,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en,
  input  logic              baud_tick,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  output logic              txd,
  output logic              tx_ready
);

  logic [DATA_W-1:0] hold_q;
  logic              wr_accept;
  logic              load_evt;
  logic              sh_busy;
  logic              frame_done;
  logic              bit_end;
  logic              sh_empty;

  // Shifter is free when idle or finishing its stop bit this cycle
  assign sh_empty = !sh_busy || frame_done;
  // A low ready flag marks a character waiting in the holding register
  assign load_evt = sh_empty && !tx_ready;

  tx_hold_reg #(.DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_stb    (wr_stb),
    .wr_data   (wr_data),
    .tx_en     (tx_en),
    .load_evt  (load_evt),
    .hold_q    (hold_q),
    .ready_q   (tx_ready),
    .wr_accept (wr_accept)
  );

  tx_bit_timer #(.TICKS_PER_BIT(TICKS_PER_BIT)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (sh_busy),
    .restart   (load_evt),
    .baud_tick (baud_tick),
    .bit_end   (bit_end)
  );

  tx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load_evt),
    .load_data  (hold_q),
    .bit_end    (bit_end),
    .txd        (txd),
    .busy       (sh_busy),
    .frame_done (frame_done)
  );

endmodule

// File: rtl/uart_tx_buffer_chk.sv
module uart_tx_buffer_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tx_en,
  input logic              wr_stb,
  input logic              tx_ready,
  input logic              txd,
  input logic              wr_accept,
  input logic              load_evt,
  input logic              frame_done,
  input logic              sh_busy,
  input logic [DATA_W-1:0] hold_q
);

  a_r2_write_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> !tx_ready);

  a_r3_hold_kept_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !tx_ready) |=> $stable(hold_q));

  a_r4_hold_kept_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && !tx_en) |=> $stable(hold_q));

  a_r5_load_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> tx_ready);

  a_r5_start_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (!txd && sh_busy));

  a_r5_write_load_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_accept, load_evt}));

  a_r8_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !tx_ready) |-> load_evt);

  a_r9_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !sh_busy |-> txd);

endmodule

bind uart_tx_buffer uart_tx_buffer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tx_en      (tx_en),
  .wr_stb     (wr_stb),
  .tx_ready   (tx_ready),
  .txd        (txd),
  .wr_accept  (wr_accept),
  .load_evt   (load_evt),
  .frame_done (frame_done),
  .sh_busy    (sh_busy),
  .hold_q     (hold_q)
);

// File: tb/uart_tx_buffer_tb.sv
module uart_tx_buffer_tb;

  localparam int TPB         = 16;
  localparam int FRAME_TICKS = 10 * TPB;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_en = 1'b0;
  logic       baud_tick = 1'b0;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       txd;
  logic       tx_ready;

  int         n_tests = 0;
  int         n_fail = 0;
  int         cyc = 0;
  bit         done = 1'b0;

  logic       tick_seen = 1'b0;
  bit         hold_full = 1'b0;
  bit         acc_prev = 1'b0;
  bit         mon_busy = 1'b0;
  int         mon_cnt = 0;
  logic [7:0] cur_byte = 8'h00;
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;

  uart_tx_buffer u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_en     (tx_en),
    .baud_tick (baud_tick),
    .wr_stb    (wr_stb),
    .wr_data   (wr_data),
    .txd       (txd),
    .tx_ready  (tx_ready)
  );

  // Tick value the design consumed at the last rising edge
  always @(posedge clk) tick_seen <= baud_tick;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: act=%0d cycles exp=<150000", cyc);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests = n_tests + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: act=%0h exp=%0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // Expected serial level of bit b in a frame carrying byte d (R6)
  function automatic logic frame_bit(input logic [7:0] d, input int b);
    if (b == 0) return 1'b0;
    if (b == 9) return 1'b1;
    return d[b-1];
  endfunction

  // One cycle: observe and check the state after the last edge, then drive
  task automatic step(input bit stb, input logic [7:0] d, input bit en, input bit tk);
    bit frame_end;
    bit load;
    @(negedge clk);
    frame_end = 1'b0;
    if (mon_busy && tick_seen) begin
      mon_cnt = mon_cnt + 1;
      if (mon_cnt == FRAME_TICKS) begin
        frame_end = 1'b1;
        mon_busy  = 1'b0;
      end else if ((mon_cnt % TPB) == TPB / 2) begin
        // R7: bit b is sampled mid-way, counting only tick cycles
        check(txd == frame_bit(cur_byte, mon_cnt / TPB), "R6/R7 frame bit",
              int'(txd), int'(frame_bit(cur_byte, mon_cnt / TPB)));
      end
    end
    load = hold_full && !mon_busy;
    if (load) begin
      cur_byte = exp_q.pop_front();
      mon_busy = 1'b1;
      mon_cnt  = 0;
      check(txd == 1'b0, frame_end ? "R8 back-to-back start" : "R5 start after load",
            int'(txd), 0);
    end
    hold_full = (hold_full && !load) || acc_prev;
    check(tx_ready == !hold_full, acc_prev ? "R2 ready cleared" : "R5 ready flag",
          int'(tx_ready), int'(!hold_full));
    if (!mon_busy) check(txd == 1'b1, "R9 idle line", int'(txd), 1);
    wr_stb    = stb;
    wr_data   = d;
    tx_en     = en;
    baud_tick = tk;
    acc_prev  = stb && en && tx_ready;
    if (acc_prev) exp_q.push_back(d);
  endtask

  task automatic idle_until_empty(input bit tk_every);
    for (int i = 0; i < 4000 && (hold_full || mon_busy || acc_prev); i++)
      step(1'b0, 8'h00, 1'b1, tk_every ? 1'b1 : ($urandom_range(0, 2) == 0));
    step(1'b0, 8'h00, 1'b1, 1'b0);
  endtask

  initial begin
    void'($urandom(32'h1f2e3d4c));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(tx_ready == 1'b1, "R1 ready after reset", int'(tx_ready), 1);
    check(txd == 1'b1, "R1 txd after reset", int'(txd), 1);

    // R4: disabled write is dropped; line stays idle, ready stays high
    step(1'b1, 8'h5A, 1'b0, 1'b1);
    for (int i = 0; i < 5; i++) step(1'b0, 8'h00, 1'b0, 1'b1);
    check(tx_ready == 1'b1, "R4 ready after disabled write", int'(tx_ready), 1);
    check(txd == 1'b1, "R4 no frame after disabled write", int'(txd), 1);

    // R2/R5: idle write, ready dips for a single cycle, frame carries A5
    step(1'b1, 8'hA5, 1'b1, 1'b1);
    step(1'b0, 8'h00, 1'b1, 1'b1);
    check(tx_ready == 1'b0, "R2 ready low after write", int'(tx_ready), 0);
    step(1'b0, 8'h00, 1'b1, 1'b1);
    check(tx_ready == 1'b1, "R5 ready back after one cycle", int'(tx_ready), 1);
    // R3: write while full, then refused write must not replace it
    step(1'b1, 8'h3C, 1'b1, 1'b1);
    step(1'b1, 8'hFF, 1'b1, 1'b1);
    check(tx_ready == 1'b0, "R3 ready low while full", int'(tx_ready), 0);
    step(1'b1, 8'h81, 1'b1, 1'b1);
    idle_until_empty(1'b1);

    // R8: back-to-back frames with writes issued mid-frame
    step(1'b1, 8'h01, 1'b1, 1'b1);
    step(1'b0, 8'h00, 1'b1, 1'b1);
    step(1'b1, 8'h80, 1'b1, 1'b1);
    for (int i = 0; i < 200; i++) step(1'b0, 8'h00, 1'b1, 1'b1);
    step(1'b1, 8'h7E, 1'b1, 1'b1);
    idle_until_empty(1'b1);

    // R7: sparse ticks stretch bits in cycles but not in tick count
    step(1'b1, 8'hC3, 1'b1, 1'b0);
    idle_until_empty(1'b0);

    // Random mixed traffic
    for (int i = 0; i < 40000; i++)
      step($urandom_range(0, 99) < 3, 8'($urandom), $urandom_range(0, 9) != 0,
           $urandom_range(0, 1) == 0);
    idle_until_empty(1'b1);
    check(exp_q.size() == 0, "R5 all accepted characters sent", exp_q.size(), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule